// File: doc/BRIEF.md
# Private Peripheral Window Decoder

This block sits on the core-private slice of the address map, from 0xE0000000 to 0xE00FFFFF, and answers every access that lands in it. The control-space page at 0xE000E000 is routed to three stub target groups: a tick-timer pair, interrupt-enable words and a system group. The page at 0xE0005000 holds a minimal error-reporting group that describes zero error records. Every other location in the window is a hole. Holes are served by a fallback responder that sits below every explicit target in priority. A privileged access to a hole reads zero and drops writes. An unprivileged access to a hole faults.

When the security extension is built in, a secure access to the page at 0xE002E000 is treated as a non-secure access to the same offset of the control space. This is visible on the one banked stub register, the vector base. A non-secure access to that page, or any access to it when the extension is absent, is quiet: it reads as zero and drops writes.

An access is a one-cycle strobe `acc_valid` carrying its address, direction, data and attributes. The response is combinational and belongs to the same cycle. There is no back-pressure: every strobe is accepted in its cycle, so no ready signal exists. A write changes stub state at the closing clock edge. The select strobes show which target group took the access.

Top module: `ppb_decoder`

## Requirements
- R1: An access whose address bits [31:20] differ from 0xE00 is not claimed: `rsp_hit`, `rsp_fault`, `rsp_rdata` and every select stay 0.
- R2: A privileged access to an unimplemented location in the window (for example 0xE0001000 or 0xE000E500) has `rsp_hit`=1 and `rsp_fault`=0, reads 0, and a write to it changes nothing.
- R3: An unprivileged access to an unimplemented location in the window sets `rsp_fault`=1 with `rsp_rdata`=0.
- R4: An unprivileged access to an implemented register faults, drives no select and does not write. The one exception is the mailbox at control-space offset 0xF00, which is user-accessible: it takes unprivileged reads and writes without a fault.
- R5: With the security extension, a secure access to 0xE002E000+k acts as a non-secure access to control-space offset k. The vector base at offset 0xD08 has separate secure and non-secure copies. Its bits [6:0] read zero.
- R6: A non-secure access to the page 0xE002E000–0xE002EFFF reads 0, drops writes, does not fault and drives no select. When the security extension is absent, this applies to every access to that page. In that build there is a single vector base, whatever the secure flag.
- R7: The error group answers at 0xE0005E10 with the implementer value (parameter `ERR_IMPL_ID`) and at 0xE0005FC8 with a device value of 0, meaning zero records. Both are read-only. Other offsets in that page are holes. An unprivileged access to either register faults.
- R8: At most one of `sel_tick`, `sel_irq`, `sel_sys` is high. A select is high only with `acc_valid`, without a fault, and for its own group: tick for offsets 0x010/0x014, irq for the enable words, sys for 0xD00/0xD08/0xF00.
- R9: Tick control at 0xE000E010 keeps bits [2:0] of a write. Tick reload at 0xE000E014 keeps bits [23:0]. All other bits read zero.
- R10: Interrupt-enable word w is set by writing ones at 0xE000E100+4w and cleared by writing ones at 0xE000E180+4w. Both addresses read the current word. Bits for interrupt numbers at or above `NUM_IRQ` read 0. Words at or above ceil(`NUM_IRQ`/32) are holes.
- R11: The identity register at 0xE000ED00 reads `CPU_ID`, and writes to it have no effect.
- R12: After reset, all stub registers read 0.
- R13: Read data and the fault flag belong to the cycle of the strobe. A write is visible to a read in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | One-cycle access strobe |
| acc_addr | input | 32 | Byte address, word aligned |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 32 | Write data |
| acc_priv | input | 1 | Access is privileged |
| acc_secure | input | 1 | Access is from the secure state |
| rsp_hit | output | 1 | Address lies in the decoded window |
| rsp_fault | output | 1 | Bus fault for this access |
| rsp_rdata | output | 32 | Read data, 0 on writes and faults |
| sel_tick | output | 1 | Access routed to the tick stub |
| sel_irq | output | 1 | Access routed to the interrupt-enable stub |
| sel_sys | output | 1 | Access routed to the system stub |

## Verification
The assertions assume that the access inputs carry meaning only while `acc_valid` is high, and that addresses are word aligned. The quiet-alias and unprivileged-hole properties also rely on the page numbers of the window staying fixed at 0x0E, 0x2E and 0x05. The stimulus respects these assumptions. It changes inputs only at the falling edge and sends word-aligned addresses. It holds each strobe for exactly one cycle and lowers it before the next access, so every response is sampled inside its own cycle. A second instance built without the security extension receives the same stimulus, so the alias behaviour of both builds is checked against identical traffic.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
  typedef enum logic [2:0] {
    RG_OUT,
    RG_SCS,
    RG_ALIAS_RAZ,
    RG_ERR,
    RG_HOLE
  } ppb_region_e;

  localparam logic [11:0] WIN_TAG  = 12'hE00;
  localparam logic [7:0]  PG_SCS   = 8'h0E;
  localparam logic [7:0]  PG_ALIAS = 8'h2E;
  localparam logic [7:0]  PG_ERR   = 8'h05;

  localparam logic [11:0] OFF_TICK_CTRL   = 12'h010;
  localparam logic [11:0] OFF_TICK_RELOAD = 12'h014;
  localparam logic [11:0] OFF_IRQ_SET     = 12'h100;
  localparam logic [11:0] OFF_IRQ_CLR     = 12'h180;
  localparam logic [11:0] OFF_IDENT       = 12'hD00;
  localparam logic [11:0] OFF_VBASE       = 12'hD08;
  localparam logic [11:0] OFF_MAILBOX     = 12'hF00;
  localparam logic [11:0] OFF_ERR_IMPL    = 12'hE10;
  localparam logic [11:0] OFF_ERR_DEV     = 12'hFC8;
endpackage

// File: rtl/ppb_addr_decode.sv
module ppb_addr_decode
  import ppb_pkg::*;
#(
  parameter bit HAS_SECURITY = 1'b1
) (
  input  logic [31:0]  addr,
  input  logic         secure,
  output ppb_region_e  region,
  output logic [11:0]  page_off,
  output logic         bank_sec
);
  always_comb begin
    page_off = addr[11:0];
    bank_sec = 1'b0;
    region   = RG_HOLE;
    if (addr[31:20] != WIN_TAG) begin
      region = RG_OUT;
    end else begin
      unique case (addr[19:12])
        PG_SCS: begin
          region   = RG_SCS;
          bank_sec = HAS_SECURITY && secure;
        end
        PG_ALIAS: begin
          // secure view of the non-secure control space
          region = (HAS_SECURITY && secure) ? RG_SCS : RG_ALIAS_RAZ;
        end
        PG_ERR:  region = RG_ERR;
        default: region = RG_HOLE;
      endcase
    end
  end
endmodule

// File: rtl/ppb_scs_stubs.sv
module ppb_scs_stubs
  import ppb_pkg::*;
#(
  parameter int          NUM_IRQ          = 40,
  parameter logic [31:0] CPU_ID           = 32'h4D31_0A01,
  parameter int          TICK_CTRL_BITS   = 3,
  parameter int          TICK_RELOAD_BITS = 24,
  parameter int          VBASE_ALIGN      = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic [11:0] off,
  input  logic        bank_sec,
  output logic        hit_tick,
  output logic        hit_irq,
  output logic        hit_sys,
  output logic        user_ok,
  output logic [31:0] rdata
);
  localparam int          IRQ_WORDS   = (NUM_IRQ + 31) / 32;
  localparam logic [31:0] CTRL_MASK   = 32'((64'd1 << TICK_CTRL_BITS) - 64'd1);
  localparam logic [31:0] RELOAD_MASK = 32'((64'd1 << TICK_RELOAD_BITS) - 64'd1);
  localparam logic [31:0] VBASE_MASK  = ~32'((64'd1 << VBASE_ALIGN) - 64'd1);

  function automatic logic [31:0] word_mask(input int w);
    logic [31:0] m;
    for (int b = 0; b < 32; b++) m[b] = ((w * 32 + b) < NUM_IRQ);
    return m;
  endfunction

  logic [31:0] tick_ctrl_q, tick_reload_q;
  logic [31:0] vbase_s_q, vbase_ns_q, mailbox_q;
  logic [IRQ_WORDS-1:0]       irq_word_hit;
  logic [IRQ_WORDS-1:0][31:0] irq_word_rd;

  generate
    for (genvar w = 0; w < IRQ_WORDS; w++) begin : g_irq
      localparam logic [11:0] SET_OFF = OFF_IRQ_SET + 12'(w * 4);
      localparam logic [11:0] CLR_OFF = OFF_IRQ_CLR + 12'(w * 4);
      localparam logic [31:0] MASK    = word_mask(w);
      logic [31:0] en_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        en_q <= '0;
        else if (wr_en && off == SET_OFF)  en_q <= en_q | (wdata & MASK);
        else if (wr_en && off == CLR_OFF)  en_q <= en_q & ~wdata;
      end
      assign irq_word_hit[w] = (off == SET_OFF) || (off == CLR_OFF);
      assign irq_word_rd[w]  = irq_word_hit[w] ? en_q : '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_ctrl_q   <= '0;
      tick_reload_q <= '0;
      vbase_s_q     <= '0;
      vbase_ns_q    <= '0;
      mailbox_q     <= '0;
    end else if (wr_en) begin
      unique case (off)
        OFF_TICK_CTRL:   tick_ctrl_q   <= wdata & CTRL_MASK;
        OFF_TICK_RELOAD: tick_reload_q <= wdata & RELOAD_MASK;
        OFF_VBASE: begin
          if (bank_sec) vbase_s_q  <= wdata & VBASE_MASK;
          else          vbase_ns_q <= wdata & VBASE_MASK;
        end
        OFF_MAILBOX:     mailbox_q     <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    hit_tick = (off == OFF_TICK_CTRL) || (off == OFF_TICK_RELOAD);
    hit_irq  = |irq_word_hit;
    hit_sys  = (off == OFF_IDENT) || (off == OFF_VBASE) || (off == OFF_MAILBOX);
    user_ok  = (off == OFF_MAILBOX);
    rdata    = '0;
    for (int w = 0; w < IRQ_WORDS; w++) rdata = rdata | irq_word_rd[w];
    unique case (off)
      OFF_TICK_CTRL:   rdata = tick_ctrl_q;
      OFF_TICK_RELOAD: rdata = tick_reload_q;
      OFF_IDENT:       rdata = CPU_ID;
      OFF_VBASE:       rdata = bank_sec ? vbase_s_q : vbase_ns_q;
      OFF_MAILBOX:     rdata = mailbox_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/ppb_err_group.sv
module ppb_err_group
  import ppb_pkg::*;
#(
  parameter logic [31:0] IMPL_ID = 32'h0A5C_0001,
  parameter logic [31:0] DEV_ID  = 32'h0000_0000
) (
  input  logic [11:0] off,
  output logic        hit,
  output logic [31:0] rdata
);
  always_comb begin
    hit   = 1'b1;
    rdata = '0;
    unique case (off)
      OFF_ERR_IMPL: rdata = IMPL_ID;
      OFF_ERR_DEV:  rdata = DEV_ID;
      default:      hit   = 1'b0;
    endcase
  end
endmodule

// File: rtl/ppb_decoder.sv
module ppb_decoder
  import ppb_pkg::*;
#(
  parameter bit          HAS_SECURITY = 1'b1,
  parameter int          NUM_IRQ      = 40,
  parameter logic [31:0] CPU_ID       = 32'h4D31_0A01,
  parameter logic [31:0] ERR_IMPL_ID  = 32'h0A5C_0001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic [31:0] acc_addr,
  input  logic        acc_write,
  input  logic [31:0] acc_wdata,
  input  logic        acc_priv,
  input  logic        acc_secure,
  output logic        rsp_hit,
  output logic        rsp_fault,
  output logic [31:0] rsp_rdata,
  output logic        sel_tick,
  output logic        sel_irq,
  output logic        sel_sys
);
  ppb_region_e region;
  logic [11:0] page_off;
  logic        bank_sec;
  logic        scs_tick, scs_irq, scs_sys, scs_user, scs_wr;
  logic [31:0] scs_rdata, err_rdata;
  logic        err_hit;
  logic        in_win, is_scs, user_pass, fault_c, ok_c;

  ppb_addr_decode #(.HAS_SECURITY(HAS_SECURITY)) u_dec (
    .addr(acc_addr), .secure(acc_secure),
    .region(region), .page_off(page_off), .bank_sec(bank_sec)
  );

  ppb_scs_stubs #(.NUM_IRQ(NUM_IRQ), .CPU_ID(CPU_ID)) u_scs (
    .clk(clk), .rst_n(rst_n), .wr_en(scs_wr), .wdata(acc_wdata),
    .off(page_off), .bank_sec(bank_sec),
    .hit_tick(scs_tick), .hit_irq(scs_irq), .hit_sys(scs_sys),
    .user_ok(scs_user), .rdata(scs_rdata)
  );

  ppb_err_group #(.IMPL_ID(ERR_IMPL_ID)) u_err (
    .off(page_off), .hit(err_hit), .rdata(err_rdata)
  );

  always_comb begin
    in_win    = (region != RG_OUT);
    is_scs    = (region == RG_SCS);
    user_pass = is_scs && scs_user;
    // explicit targets first; the fallback only sees what they leave
    fault_c   = acc_valid && in_win && (region != RG_ALIAS_RAZ)
                && !acc_priv && !user_pass;
    ok_c      = acc_valid && in_win && !fault_c;
    scs_wr    = ok_c && acc_write && is_scs;

    rsp_hit   = acc_valid && in_win;
    rsp_fault = fault_c;
    rsp_rdata = '0;
    if (ok_c && !acc_write) begin
      if (is_scs)                            rsp_rdata = scs_rdata;
      else if (region == RG_ERR && err_hit)  rsp_rdata = err_rdata;
    end
    sel_tick  = ok_c && is_scs && scs_tick;
    sel_irq   = ok_c && is_scs && scs_irq;
    sel_sys   = ok_c && is_scs && scs_sys;
  end
endmodule

// File: rtl/ppb_decoder_chk.sv
module ppb_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic [31:0] acc_addr,
  input logic        acc_write,
  input logic [31:0] acc_wdata,
  input logic        acc_priv,
  input logic        acc_secure,
  input logic        rsp_hit,
  input logic        rsp_fault,
  input logic [31:0] rsp_rdata,
  input logic        sel_tick,
  input logic        sel_irq,
  input logic        sel_sys
);
  logic       in_win;
  logic [7:0] page;
  logic       known_page;
  logic       any_sel;
  logic       unused_ok;

  assign in_win     = (acc_addr[31:20] == 12'hE00);
  assign page       = acc_addr[19:12];
  assign known_page = (page == 8'h0E) || (page == 8'h2E) || (page == 8'h05);
  assign any_sel    = sel_tick | sel_irq | sel_sys;
  assign unused_ok  = acc_write ^ (|acc_wdata);

  AST_OUT_UNCLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !in_win |-> !rsp_hit && !rsp_fault && rsp_rdata == 32'h0 && !any_sel); // R1
  AST_PRIV_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_priv |-> !rsp_fault); // R2
  AST_UNPRIV_HOLE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_priv && in_win && !known_page |-> rsp_fault); // R3
  AST_FAULT_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_rdata == 32'h0 && !any_sel); // R4
  AST_ALIAS_NS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && in_win && page == 8'h2E && !acc_secure |-> !rsp_fault && rsp_rdata == 32'h0 && !any_sel); // R6
  AST_ERR_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && in_win && page == 8'h05 |-> !any_sel); // R7
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_tick, sel_irq, sel_sys})); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !rsp_hit && !rsp_fault && !any_sel); // R8
endmodule

bind ppb_decoder ppb_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_write(acc_write), .acc_wdata(acc_wdata), .acc_priv(acc_priv),
  .acc_secure(acc_secure), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
  .rsp_rdata(rsp_rdata), .sel_tick(sel_tick), .sel_irq(sel_irq), .sel_sys(sel_sys)
);

// File: tb/ppb_decoder_tb_top.sv
module ppb_decoder_tb_top;
  localparam logic [31:0] CPU_ID  = 32'h4D31_0A01;
  localparam logic [31:0] IMPL_ID = 32'h0A5C_0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0, acc_priv = 1'b0, acc_secure = 1'b0;
  logic [31:0] acc_addr = '0, acc_wdata = '0;
  logic hit, fault, s_tick, s_irq, s_sys;
  logic [31:0] rdata;
  logic n_hit, n_fault, n_tick, n_irq, n_sys;
  logic [31:0] n_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic g_hit, g_fault, gn_hit, gn_fault;
  logic [2:0] g_sel;
  logic [31:0] g_rd, gn_rd;

  always #5 clk = ~clk;

  ppb_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .acc_wdata(acc_wdata), .acc_priv(acc_priv),
    .acc_secure(acc_secure), .rsp_hit(hit), .rsp_fault(fault), .rsp_rdata(rdata),
    .sel_tick(s_tick), .sel_irq(s_irq), .sel_sys(s_sys)
  );

  ppb_decoder #(.HAS_SECURITY(1'b0)) dut_nosec_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .acc_wdata(acc_wdata), .acc_priv(acc_priv),
    .acc_secure(acc_secure), .rsp_hit(n_hit), .rsp_fault(n_fault), .rsp_rdata(n_rdata),
    .sel_tick(n_tick), .sel_irq(n_irq), .sel_sys(n_sys)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one access: drive at falling edge, sample before the rising edge
  task automatic acc(input logic [31:0] a, input logic wr, input logic [31:0] d,
                     input logic pv, input logic sc);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_write = wr; acc_wdata = d;
    acc_priv = pv; acc_secure = sc;
    #1;
    g_hit = hit; g_fault = fault; g_rd = rdata; g_sel = {s_tick, s_irq, s_sys};
    gn_hit = n_hit; gn_fault = n_fault; gn_rd = n_rdata;
    @(posedge clk);
    #1;
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check("R12", "idle hit", {31'd0, hit}, 32'd0);
    acc(32'hE000E010, 0, 0, 1, 0); check("R12", "tick ctrl", g_rd, 32'd0);
    acc(32'hE000E014, 0, 0, 1, 0); check("R12", "tick reload", g_rd, 32'd0);
    acc(32'hE000E100, 0, 0, 1, 0); check("R12", "irq word0", g_rd, 32'd0);
    acc(32'hE000ED08, 0, 0, 1, 0); check("R12", "vbase", g_rd, 32'd0);
    acc(32'hE000EF00, 0, 0, 1, 0); check("R12", "mailbox", g_rd, 32'd0);
  endtask

  task automatic t_outside();
    acc(32'hE0100000, 0, 0, 1, 0);
    check("R1", "above hit/fault", {30'd0, g_hit, g_fault}, 32'd0);
    acc(32'hDFFFFFFC, 1, 32'hFFFFFFFF, 0, 0);
    check("R1", "below hit/fault/sel", {27'd0, g_sel, g_hit, g_fault}, 32'd0);
  endtask

  task automatic t_holes();
    acc(32'hE0001000, 1, 32'h5555AAAA, 1, 0);
    check("R2", "hole write hit/fault", {30'd0, g_hit, g_fault}, 32'd2);
    acc(32'hE0001000, 0, 0, 1, 0);
    check("R2", "hole read", g_rd, 32'd0);
    acc(32'hE000E500, 0, 0, 1, 0);
    check("R2", "scs hole read/fault", {g_rd[30:0], g_fault}, 32'd0);
    acc(32'hE0001000, 0, 0, 0, 0);
    check("R3", "unpriv hole fault", {31'd0, g_fault}, 32'd1);
    check("R3", "unpriv hole data", g_rd, 32'd0);
    acc(32'hE000E500, 0, 0, 0, 1);
    check("R3", "unpriv scs hole fault", {31'd0, g_fault}, 32'd1);
  endtask

  task automatic t_tick();
    acc(32'hE000E010, 1, 32'hFFFFFFFF, 1, 0);
    check("R8", "tick select", {29'd0, g_sel}, 32'd4);
    acc(32'hE000E010, 0, 0, 1, 0);
    check("R9", "ctrl mask", g_rd, 32'h7);
    check("R13", "read next cycle after write", {31'd0, g_fault}, 32'd0);
    acc(32'hE000E014, 1, 32'hFFFFFFFF, 1, 0);
    acc(32'hE000E014, 0, 0, 1, 0);
    check("R9", "reload mask", g_rd, 32'h00FFFFFF);
  endtask

  task automatic t_irq();
    acc(32'hE000E100, 1, 32'h000000F0, 1, 0);
    check("R8", "irq select", {29'd0, g_sel}, 32'd2);
    acc(32'hE000E180, 0, 0, 1, 0);
    check("R10", "set then read clr alias", g_rd, 32'h000000F0);
    acc(32'hE000E180, 1, 32'h00000030, 1, 0);
    acc(32'hE000E100, 0, 0, 1, 0);
    check("R10", "clear by ones", g_rd, 32'h000000C0);
    acc(32'hE000E104, 1, 32'hFFFFFFFF, 1, 0);
    acc(32'hE000E104, 0, 0, 1, 0);
    check("R10", "bits past NUM_IRQ", g_rd, 32'h000000FF);
    acc(32'hE000E108, 1, 32'hFFFFFFFF, 1, 0);
    check("R10", "word past count no select", {29'd0, g_sel}, 32'd0);
    acc(32'hE000E108, 0, 0, 1, 0);
    check("R10", "word past count reads 0", g_rd, 32'd0);
  endtask

  task automatic t_ident();
    acc(32'hE000ED00, 0, 0, 1, 0);
    check("R11", "ident", g_rd, CPU_ID);
    check("R8", "sys select", {29'd0, g_sel}, 32'd1);
    acc(32'hE000ED00, 1, 32'h0, 1, 0);
    acc(32'hE000ED00, 0, 0, 1, 0);
    check("R11", "ident after write", g_rd, CPU_ID);
  endtask

  task automatic t_unpriv();
    acc(32'hE000E014, 1, 32'h00001234, 0, 0);
    check("R4", "unpriv reg fault", {31'd0, g_fault}, 32'd1);
    check("R4", "unpriv reg no select", {29'd0, g_sel}, 32'd0);
    acc(32'hE000E014, 0, 0, 1, 0);
    check("R4", "reload kept", g_rd, 32'h00FFFFFF);
    acc(32'hE000EF00, 1, 32'hCAFEF00D, 0, 0);
    check("R4", "mailbox unpriv write fault", {31'd0, g_fault}, 32'd0);
    acc(32'hE000EF00, 0, 0, 0, 0);
    check("R4", "mailbox unpriv read", g_rd, 32'hCAFEF00D);
  endtask

  task automatic t_alias();
    acc(32'hE002ED08, 1, 32'h00012345, 1, 1);
    acc(32'hE000ED08, 0, 0, 1, 0);
    check("R5", "ns copy via alias", g_rd, 32'h00012300);
    acc(32'hE000ED08, 0, 0, 1, 1);
    check("R5", "secure copy untouched", g_rd, 32'd0);
    acc(32'hE000ED08, 1, 32'h00ABCD00, 1, 1);
    acc(32'hE002ED08, 0, 0, 1, 1);
    check("R5", "alias reads ns copy", g_rd, 32'h00012300);
    acc(32'hE002EF00, 0, 0, 0, 1);
    check("R5", "alias unpriv mailbox", g_rd, 32'hCAFEF00D);
    acc(32'hE002ED08, 0, 0, 0, 1);
    check("R5", "alias unpriv vbase fault", {31'd0, g_fault}, 32'd1);
  endtask

  task automatic t_alias_quiet();
    acc(32'hE002ED08, 1, 32'hFFFFFF00, 1, 0);
    check("R6", "ns alias write", {27'd0, g_sel, g_hit, g_fault}, 32'd2);
    acc(32'hE000ED08, 0, 0, 1, 0);
    check("R6", "ns copy unchanged", g_rd, 32'h00012300);
    acc(32'hE002EF00, 0, 0, 0, 0);
    check("R6", "ns unpriv alias quiet", {g_rd[30:0], g_fault}, 32'd0);
    acc(32'hE002EF00, 0, 0, 1, 1);
    check("R6", "no-ext alias secure read", gn_rd, 32'd0);
    check("R6", "no-ext alias fault", {30'd0, gn_hit, gn_fault}, 32'd2);
    acc(32'hE000ED08, 0, 0, 1, 0);
    check("R6", "no-ext single vbase", gn_rd, 32'h00ABCD00);
  endtask

  task automatic t_err();
    acc(32'hE0005E10, 0, 0, 1, 0);
    check("R7", "impl id", g_rd, IMPL_ID);
    acc(32'hE0005FC8, 1, 32'hFFFFFFFF, 1, 0);
    check("R7", "err no select", {29'd0, g_sel}, 32'd0);
    acc(32'hE0005FC8, 0, 0, 1, 0);
    check("R7", "device id zero records", g_rd, 32'd0);
    acc(32'hE0005000, 0, 0, 1, 0);
    check("R7", "err hole", {g_rd[29:0], g_hit, g_fault}, 32'd2);
    acc(32'hE0005E10, 0, 0, 0, 0);
    check("R7", "err unpriv fault", {31'd0, g_fault}, 32'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_outside();
    t_holes();
    t_tick();
    t_irq();
    t_ident();
    t_unpriv();
    t_alias();
    t_alias_quiet();
    t_err();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule